// File: doc/BRIEF.md
# Address Translation Window Table

This block maps incoming addresses from several source ports to translated addresses and a destination identifier. Each source port owns a fixed number of translation tables. A table entry holds a source base, a translated base, a power-of-two window size code, an enable bit, a pass-through flag and a destination code. The default build has six source ports, in this order: two PCIe windows (ports 0 and 1), then four AXI slave ports (ports 2 to 5). Each port has two tables.

Each cycle, a port can present one address with a valid strobe. The address is compared against every enabled entry of that port. One clock later the port reports either a translated address with its destination code, or a miss. A simple 32-bit host register interface programs the tables. The 64-bit registers are written as two halves, and an entry changes only when its high half is written.

Top module: `addr_xlate_table`

## Requirements
- R1: After a synchronous active-high reset, every entry is disabled and reads back as zero. No port reports a result, and `host_rdata` is zero.
- R2: Source register layout: bit 0 is the enable, bits 6:1 hold a size code c, and bits 63:12 hold the base. The window spans 2^(c+1) bytes but never less than 4 KiB, so address bits 11:0 are never compared. Bits 11:7 read back as zero.
- R3: Writing a low word (word 0 or 2) only places it in a staging register and changes no entry. The following high-word write (word 1 or 3) commits the staged low half and the new high half together.
- R4: Writing zero to both halves of an entry's source register disables that entry, and lookups no longer hit it.
- R5: For a non-transparent hit, the output address is the translated base above the window boundary joined with the incoming address below it. Base bits below the window are ignored. Translated-base bits 11:0 read back as zero.
- R6: An entry whose parameter bit 3 (pass-through) is set matches any address and forwards the address unchanged.
- R7: Parameter bits 2:0 hold the destination code: 0 PCIe transaction, 1 PCIe configuration, 4 to 7 AXI master 0 to 3. An entry holding code 2 or 3 never hits.
- R8: When several enabled entries of one port match, the lowest-numbered table supplies the result.
- R9: A valid lookup with no hit raises that port's miss flag one cycle later. In that cycle `rs_valid` is low and the address and destination outputs are zero.
- R10: The result appears exactly one clock after the lookup strobe. A lookup in the same cycle as an entry-changing write sees the entry as it was before the write.
- R11: The host word address is decoded as follows: bits 4:2 select the word (0/1 source low/high, 2/3 translated low/high, 4 parameter), the next bit selects the table, and the bits above it select the port. Writes to a port number of 6 or more are ignored, and reads from it return zero. Read data appears on the cycle after the read strobe and holds until the next read.
- R12: Reading back a register returns the committed value, with the masked bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| lk_valid | input | 6 | Per-port lookup strobe |
| lk_addr | input | 384 | Per-port lookup address, 64 bits each |
| rs_valid | output | 6 | Per-port translation hit |
| rs_miss | output | 6 | Per-port miss flag |
| rs_addr | output | 384 | Per-port translated address |
| rs_dest | output | 18 | Per-port destination code, 3 bits each |

## Verification
A host write that commits an entry and a lookup through that entry can fall in the same cycle. The bench drives a parameter write that invalidates the entry's destination on the same clock edge as a lookup on that port. It expects the lookup to return the old destination, and a following lookup to miss. A behavioural model that applies lookups before writes on each edge is compared with every output on every clock, so any ordering slip elsewhere in the run is also caught.

// File: rtl/axt_pkg.sv
package axt_pkg;
  localparam int ADDR_W    = 64;
  localparam int PAGE_BITS = 12;
  localparam int CODE_W    = 6;

  localparam logic [2:0] W_SRC_LO  = 3'd0;
  localparam logic [2:0] W_SRC_HI  = 3'd1;
  localparam logic [2:0] W_TRSL_LO = 3'd2;
  localparam logic [2:0] W_TRSL_HI = 3'd3;
  localparam logic [2:0] W_PARAM   = 3'd4;

  typedef enum logic [2:0] {
    DST_PCIE_TX  = 3'd0,
    DST_PCIE_CFG = 3'd1,
    DST_AXI_M0   = 3'd4,
    DST_AXI_M1   = 3'd5,
    DST_AXI_M2   = 3'd6,
    DST_AXI_M3   = 3'd7
  } dest_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;   // [0] enable, [6:1] size code, [63:12] base
    logic [ADDR_W-1:0] trsl;  // [63:12] translated base
    logic              pass;  // forward unchanged
    logic [2:0]        dest;
  } entry_t;

  // Mask of address bits above the window boundary
  function automatic logic [ADDR_W-1:0] win_mask(input logic [CODE_W-1:0] code);
    int w;
    logic [ADDR_W-1:0] m;
    w = int'(code) + 1;
    if (w < PAGE_BITS) w = PAGE_BITS;
    if (w >= ADDR_W) m = '0;
    else m = ~((ADDR_W'(1) << w) - ADDR_W'(1));
    return m;
  endfunction

  function automatic logic dest_ok(input logic [2:0] d);
    return (d != 3'd2) && (d != 3'd3);
  endfunction
endpackage

// File: rtl/axt_regfile.sv
module axt_regfile
  import axt_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int NUM_TABLES = 2,
  localparam int N       = NUM_PORTS * NUM_TABLES,
  localparam int TBL_W   = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1,
  localparam int PORT_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int HOST_AW = 5 + TBL_W + PORT_W,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic               host_re,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output entry_t [N-1:0]     tbl_o
);
  entry_t [N-1:0] tbl_q;
  logic [19:0]    hold_base;
  logic [6:0]     hold_low;
  logic [31:0]    rdata_q;

  logic [2:0]        word;
  logic [TBL_W-1:0]  tsel;
  logic [PORT_W-1:0] psel;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic              unused_param_bits;

  assign word     = host_addr[4:2];
  assign tsel     = host_addr[5 +: TBL_W];
  assign psel     = host_addr[5 + TBL_W +: PORT_W];
  assign in_range = (int'(psel) < NUM_PORTS) && (int'(tsel) < NUM_TABLES);
  assign idx      = IDX_W'(int'(psel) * NUM_TABLES + int'(tsel));
  assign unused_param_bits = ^{host_wdata[31:20], host_wdata[11:7], host_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q     <= '0;
      hold_base <= '0;
      hold_low  <= '0;
    end else if (host_we) begin
      if (word == W_SRC_LO || word == W_TRSL_LO) begin
        hold_base <= host_wdata[31:12];
        hold_low  <= host_wdata[6:0];
      end
      if (in_range) begin
        case (word)
          W_SRC_HI:  tbl_q[idx].src  <= {host_wdata, hold_base, 5'b0, hold_low};
          W_TRSL_HI: tbl_q[idx].trsl <= {host_wdata, hold_base, 12'b0};
          W_PARAM: begin
            tbl_q[idx].dest <= host_wdata[2:0];
            tbl_q[idx].pass <= host_wdata[3];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (host_re) begin
      if (!in_range) rdata_q <= '0;
      else begin
        case (word)
          W_SRC_LO:  rdata_q <= tbl_q[idx].src[31:0];
          W_SRC_HI:  rdata_q <= tbl_q[idx].src[63:32];
          W_TRSL_LO: rdata_q <= tbl_q[idx].trsl[31:0];
          W_TRSL_HI: rdata_q <= tbl_q[idx].trsl[63:32];
          W_PARAM:   rdata_q <= {28'b0, tbl_q[idx].pass, tbl_q[idx].dest};
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign tbl_o      = tbl_q;
  assign host_rdata = rdata_q;

  // R3
  lo_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && (word == W_SRC_LO || word == W_TRSL_LO)) |=> $stable(tbl_q));

  // R3
  src_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && in_range && word == W_SRC_HI) |=> (tbl_q[$past(idx)].src[63:32] == $past(host_wdata)));

  // R11
  oor_write_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && !in_range) |=> $stable(tbl_q));
endmodule

// File: rtl/axt_port_lookup.sv
module axt_port_lookup
  import axt_pkg::*;
#(
  parameter int NUM_TABLES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [ADDR_W-1:0]       in_addr,
  input  entry_t [NUM_TABLES-1:0] tbls,
  output logic                    out_valid,
  output logic                    out_miss,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [2:0]              out_dest
);
  logic [NUM_TABLES-1:0] hit;
  logic [ADDR_W-1:0]     xlat [NUM_TABLES];

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    logic [ADDR_W-1:0] m;
    assign m = win_mask(tbls[t].src[CODE_W:1]);
    assign hit[t] = tbls[t].src[0] && dest_ok(tbls[t].dest) &&
                    (tbls[t].pass || (((in_addr ^ tbls[t].src) & m) == '0));
    assign xlat[t] = tbls[t].pass ? in_addr : ((tbls[t].trsl & m) | (in_addr & ~m));
  end

  logic              any_hit;
  logic [ADDR_W-1:0] sel_addr;
  logic [2:0]        sel_dest;

  always_comb begin
    any_hit  = 1'b0;
    sel_addr = '0;
    sel_dest = '0;
    for (int t = NUM_TABLES - 1; t >= 0; t--) begin
      if (hit[t]) begin
        any_hit  = 1'b1;
        sel_addr = xlat[t];
        sel_dest = tbls[t].dest;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_addr  <= '0;
      out_dest  <= '0;
    end else begin
      out_valid <= in_valid && any_hit;
      out_miss  <= in_valid && !any_hit;
      out_addr  <= (in_valid && any_hit) ? sel_addr : '0;
      out_dest  <= (in_valid && any_hit) ? sel_dest : '0;
    end
  end

  // R10
  resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid || out_miss));

  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(out_valid || out_miss));

  // R7
  dest_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dest != 3'd2 && out_dest != 3'd3));

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_addr == '0 && out_dest == 3'd0 && !out_valid));
endmodule

// File: rtl/addr_xlate_table.sv
module addr_xlate_table
  import axt_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int NUM_TABLES = 2,
  localparam int TBL_W   = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1,
  localparam int PORT_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int HOST_AW = 5 + TBL_W + PORT_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        host_we,
  input  logic                        host_re,
  input  logic [HOST_AW-1:0]          host_addr,
  input  logic [31:0]                 host_wdata,
  output logic [31:0]                 host_rdata,
  input  logic [NUM_PORTS-1:0]        lk_valid,
  input  logic [NUM_PORTS*ADDR_W-1:0] lk_addr,
  output logic [NUM_PORTS-1:0]        rs_valid,
  output logic [NUM_PORTS-1:0]        rs_miss,
  output logic [NUM_PORTS*ADDR_W-1:0] rs_addr,
  output logic [NUM_PORTS*3-1:0]      rs_dest
);
  entry_t [NUM_PORTS*NUM_TABLES-1:0] tbl_all;

  axt_regfile #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_TABLES(NUM_TABLES)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_re   (host_re),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .tbl_o     (tbl_all)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    axt_port_lookup #(
      .NUM_TABLES(NUM_TABLES)
    ) u_look (
      .clk      (clk),
      .rst      (rst),
      .in_valid (lk_valid[p]),
      .in_addr  (lk_addr[p*ADDR_W +: ADDR_W]),
      .tbls     (tbl_all[p*NUM_TABLES +: NUM_TABLES]),
      .out_valid(rs_valid[p]),
      .out_miss (rs_miss[p]),
      .out_addr (rs_addr[p*ADDR_W +: ADDR_W]),
      .out_dest (rs_dest[p*3 +: 3])
    );
  end
endmodule

// File: tb/addr_xlate_table_tb.sv
module addr_xlate_table_tb;
  localparam int NP = 6;
  localparam int NT = 2;
  localparam int NE = NP * NT;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             host_we = 1'b0;
  logic             host_re = 1'b0;
  logic [8:0]       host_addr = '0;
  logic [31:0]      host_wdata = '0;
  logic [31:0]      host_rdata;
  logic [NP-1:0]    lk_valid = '0;
  logic [NP*64-1:0] lk_addr = '0;
  logic [NP-1:0]    rs_valid;
  logic [NP-1:0]    rs_miss;
  logic [NP*64-1:0] rs_addr;
  logic [NP*3-1:0]  rs_dest;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  addr_xlate_table #(.NUM_PORTS(NP), .NUM_TABLES(NT)) u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .rs_valid(rs_valid),
    .rs_miss(rs_miss), .rs_addr(rs_addr), .rs_dest(rs_dest)
  );

  // ---------------- reference model ----------------
  bit [63:0] m_src  [NE];
  bit [63:0] m_trsl [NE];
  bit        m_pass [NE];
  bit [2:0]  m_dest [NE];
  bit [31:0] m_hold;
  bit        e_valid [NP];
  bit        e_miss  [NP];
  bit [63:0] e_addr  [NP];
  bit [2:0]  e_dest  [NP];
  bit [31:0] e_rdata;

  function automatic void ref_look(input int p, input bit [63:0] a,
                                   output bit v, output bit [63:0] oa, output bit [2:0] od);
    v = 0; oa = 0; od = 0;
    for (int t = NT - 1; t >= 0; t--) begin
      int i;
      int w;
      bit [63:0] m;
      i = p * NT + t;
      if (m_src[i][0] && m_dest[i] != 3'd2 && m_dest[i] != 3'd3) begin
        w = int'(m_src[i][6:1]) + 1;
        if (w < 12) w = 12;
        m = (w >= 64) ? 64'd0 : ~((64'd1 << w) - 64'd1);
        if (m_pass[i]) begin
          v = 1; oa = a; od = m_dest[i];
        end else if (((a ^ m_src[i]) & m) == 64'd0) begin
          v = 1; oa = (m_trsl[i] & m) | (a & ~m); od = m_dest[i];
        end
      end
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NE; i++) begin
        m_src[i] = 0; m_trsl[i] = 0; m_pass[i] = 0; m_dest[i] = 0;
      end
      m_hold = 0; e_rdata = 0;
      for (int p = 0; p < NP; p++) begin
        e_valid[p] = 0; e_miss[p] = 0; e_addr[p] = 0; e_dest[p] = 0;
      end
    end else begin
      int pn, tn, wd, ix;
      pn = int'(host_addr[8:6]); tn = int'(host_addr[5]); wd = int'(host_addr[4:2]);
      ix = pn * NT + tn;
      for (int p = 0; p < NP; p++) begin
        bit v; bit [63:0] oa; bit [2:0] od;
        ref_look(p, lk_addr[p*64 +: 64], v, oa, od);
        e_valid[p] = lk_valid[p] && v;
        e_miss[p]  = lk_valid[p] && !v;
        e_addr[p]  = e_valid[p] ? oa : 64'd0;
        e_dest[p]  = e_valid[p] ? od : 3'd0;
      end
      if (host_re) begin
        if (pn >= NP) e_rdata = 0;
        else case (wd)
          0: e_rdata = m_src[ix][31:0];
          1: e_rdata = m_src[ix][63:32];
          2: e_rdata = m_trsl[ix][31:0];
          3: e_rdata = m_trsl[ix][63:32];
          4: e_rdata = {28'd0, m_pass[ix], m_dest[ix]};
          default: e_rdata = 0;
        endcase
      end
      if (host_we) begin
        if (wd == 0 || wd == 2) m_hold = host_wdata;
        if (pn < NP) begin
          if (wd == 1) m_src[ix]  = {host_wdata, m_hold & 32'hFFFF_F07F};
          if (wd == 3) m_trsl[ix] = {host_wdata, m_hold & 32'hFFFF_F000};
          if (wd == 4) begin m_dest[ix] = host_wdata[2:0]; m_pass[ix] = host_wdata[3]; end
        end
      end
    end
  end

  // R10: every output compared with the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int p = 0; p < NP; p++) begin
        checks++;
        if (rs_valid[p] !== e_valid[p] || rs_miss[p] !== e_miss[p] ||
            rs_addr[p*64 +: 64] !== e_addr[p] || rs_dest[p*3 +: 3] !== e_dest[p]) begin
          fails++;
          $display("FAIL R10 port %0d actual=%b/%b/%h/%0d expected=%b/%b/%h/%0d", p,
                   rs_valid[p], rs_miss[p], rs_addr[p*64 +: 64], rs_dest[p*3 +: 3],
                   e_valid[p], e_miss[p], e_addr[p], e_dest[p]);
        end
      end
      checks++;
      if (host_rdata !== e_rdata) begin
        fails++;
        $display("FAIL R12 rdata actual=%h expected=%h", host_rdata, e_rdata);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  function automatic logic [8:0] A(input int p, input int t, input int w);
    return 9'((p << 6) | (t << 5) | (w << 2));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic wr64(input int p, input int t, input int w, input logic [63:0] v);
    wr(A(p, t, w), v[31:0]);
    wr(A(p, t, w + 1), v[63:32]);
  endtask

  task automatic rd(input logic [8:0] a);
    host_re = 1; host_addr = a;
    @(negedge clk);
    host_re = 0;
  endtask

  task automatic lk(input int p, input logic [63:0] a);
    lk_valid[p] = 1; lk_addr[p*64 +: 64] = a;
    @(negedge clk);
    lk_valid[p] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 valid", 64'(rs_valid), 64'd0);
    chk("R1 miss", 64'(rs_miss), 64'd0);
    rd(A(0, 0, 0));
    chk("R1 rdata", 64'(host_rdata), 64'd0);

    // port 0 table 0: 1 MiB window
    wr64(0, 0, 2, 64'h0000_0007_ABC0_0000);
    wr(A(0, 0, 4), 32'd4);
    wr(A(0, 0, 0), 32'h3450_0027);
    lk(0, 64'h0000_0012_3456_789A);
    chk("R3 staged low no hit", 64'(rs_miss[0]), 64'd1);
    rd(A(0, 0, 0));
    chk("R3 staged low readback", 64'(host_rdata), 64'd0);
    wr(A(0, 0, 1), 32'h0000_0012);
    lk(0, 64'h0000_0012_3456_789A);
    chk("R5 translated addr", rs_addr[0 +: 64], 64'h0000_0007_ABC6_789A);
    chk("R7 dest axi0", 64'(rs_dest[0 +: 3]), 64'd4);
    rd(A(0, 0, 0));
    chk("R12 src lo readback", 64'(host_rdata), 64'h3450_0027);
    rd(A(0, 0, 1));
    chk("R12 src hi readback", 64'(host_rdata), 64'h12);

    // R2 masked bits and 4 KiB floor
    wr64(1, 0, 0, 64'h0000_0000_0000_0F81);
    rd(A(1, 0, 0));
    chk("R2 bits 11:7 cleared", 64'(host_rdata), 64'h1);
    lk(1, 64'h0000_0000_0000_0FFF);
    chk("R2 in 4KiB window", 64'(rs_valid[1]), 64'd1);
    lk(1, 64'h0000_0000_0000_1000);
    chk("R9 miss above window", 64'(rs_miss[1]), 64'd1);
    chk("R9 miss addr zero", rs_addr[64 +: 64], 64'd0);

    // R4 disable by zero
    wr64(1, 0, 0, 64'd0);
    lk(1, 64'h0000_0000_0000_0FFF);
    chk("R4 disabled entry", 64'(rs_miss[1]), 64'd1);

    // R6 pass-through on port 2 table 1
    wr(A(2, 1, 4), 32'h8);
    wr64(2, 1, 0, 64'h1);
    lk(2, 64'hDEAD_BEEF_1234_5678);
    chk("R6 unchanged addr", rs_addr[128 +: 64], 64'hDEAD_BEEF_1234_5678);
    chk("R6 valid", 64'(rs_valid[2]), 64'd1);

    // R8 priority on port 3
    wr64(3, 0, 2, 64'h0000_0001_0000_0000);
    wr(A(3, 0, 4), 32'd5);
    wr64(3, 0, 0, 64'h3F);
    wr64(3, 1, 2, 64'h0000_0000_0000_9000);
    wr(A(3, 1, 4), 32'd6);
    wr64(3, 1, 0, 64'h0000_0000_0000_2017);
    lk(3, 64'h2010);
    chk("R8 lowest table addr", rs_addr[192 +: 64], 64'h0000_0001_0000_2010);
    chk("R8 lowest table dest", 64'(rs_dest[9 +: 3]), 64'd5);
    wr64(3, 0, 0, 64'd0);
    lk(3, 64'h2010);
    chk("R8 second table addr", rs_addr[192 +: 64], 64'h9010);
    chk("R8 second table dest", 64'(rs_dest[9 +: 3]), 64'd6);

    // R7 unused destination code on port 4
    wr(A(4, 0, 4), 32'd2);
    wr64(4, 0, 0, 64'h7F);
    lk(4, 64'h0123_4567_89AB_CDEF);
    chk("R7 code 2 never hits", 64'(rs_miss[4]), 64'd1);
    wr(A(4, 0, 4), 32'd1);
    lk(4, 64'h0123_4567_89AB_CDEF);
    chk("R7 full-span hit", rs_addr[256 +: 64], 64'h0123_4567_89AB_CDEF);
    chk("R7 dest cfg", 64'(rs_dest[12 +: 3]), 64'd1);

    // R10 write and lookup on the same edge
    host_we = 1; host_addr = A(4, 0, 4); host_wdata = 32'd3;
    lk_valid[4] = 1; lk_addr[256 +: 64] = 64'h55;
    @(negedge clk);
    host_we = 0; lk_valid[4] = 0;
    chk("R10 old contents used", 64'(rs_valid[4]), 64'd1);
    chk("R10 old dest", 64'(rs_dest[12 +: 3]), 64'd1);
    lk(4, 64'h55);
    chk("R10 new contents next", 64'(rs_miss[4]), 64'd1);

    // R5 misaligned base and masked translated base, port 5 table 1
    wr64(5, 1, 2, 64'h0000_0008_0000_3456);
    wr(A(5, 1, 4), 32'd7);
    wr64(5, 1, 0, 64'h0000_0001_2345_501F);
    lk(5, 64'h0000_0001_2345_ABCD);
    chk("R5 low bits ignored", rs_addr[320 +: 64], 64'h0000_0008_0000_ABCD);
    rd(A(5, 1, 2));
    chk("R5 trsl lo masked", 64'(host_rdata), 64'h3000);

    // R11 out-of-range port and read latency
    wr64(7, 0, 0, 64'h3F);
    rd(A(7, 0, 0));
    chk("R11 oor reads zero", 64'(host_rdata), 64'd0);
    rd(A(5, 1, 4));
    chk("R11 param word", 64'(host_rdata), 64'd7);
    @(negedge clk);
    chk("R11 rdata holds", 64'(host_rdata), 64'd7);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule